// File: doc/BRIEF.md
# Multiplexed-Bus Modem Register Interface

This block is the host-side register file of a modem controller. A processor reaches it over an 8-bit multiplexed address/data bus. An address-latch strobe marks the address phase. An active-low chip select is captured together with the address. Active-low read and write strobes then move the data. The block holds two control registers, a tone register and a read-only detect register. Detect events arrive as one-cycle pulses, one input bit per flag. Any set flag pulls a sticky active-low interrupt low until the host reads the detect register.

The block also chooses what the clock output carries. By default it passes the crystal clock through. When the host selects the baud clock while DPSK mode is on, the output instead carries a clock divided from the crystal. All bus pins are sampled on the crystal clock, so strobe edges are found by comparing each sample with the one before it.

Register map (3-bit latched address): 0 = control A, 1 = control B, 2 = detect flags (read-only), 3 = tone, 4..7 = unused.

Top module: `modem_regif`

## Requirements
- R1: On a sampled high-to-low transition of `ale`, `ad_in[2:0]` becomes the latched register address. Later reads and writes use this address until the next such transition.
- R2: The level of `cs_n` is latched on that same `ale` transition. Changes on `cs_n` afterwards have no effect on reads or writes.
- R3: A sampled low-to-high transition of `wr_n` stores `ad_in` into the latched register, provided the latched chip select is active. The new value can be read from the next clock cycle on.
- R4: `ad_oe` is high exactly while `rd_n` is low and the latched chip select is active. When the latched chip select is inactive, no register is written.
- R5: `ad_out` carries the content of the latched register while `ad_oe` is high, and 0 otherwise. Writes to the detect register (address 2) and to addresses 4..7 are ignored, and addresses 4..7 read as 0.
- R6: A high pulse on `det_evt[i]` sets detect flag bit i. All flags are cleared by the `rd_n` low-to-high transition that ends a chip-selected read of address 2. A flag whose event arrives in that same cycle stays set.
- R7: `irq_n` is low whenever any detect flag is set, and high otherwise.
- R8: Asserting `rst_n` low clears the control registers, the tone register, the detect flags, the latched address and the latched chip select.
- R9: `clk_out` equals `clk` unless both control A bit 0 (DPSK mode) and control B bit 0 (baud select) are set. In that case `clk_out` is a clock that toggles every `DIV_HALF` crystal cycles, counted from reset release. Clearing DPSK mode returns the output to the crystal clock, whatever the value of the select bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| ale | input | 1 | Address-latch strobe; the falling transition latches address and chip select |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; the rising transition writes |
| ad_in | input | 8 | Bus value driven by the host |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Bus output enable (bus is tristated when low) |
| det_evt | input | DET_W | Detect event pulses, one bit per flag |
| irq_n | output | 1 | Sticky active-low interrupt |
| clk_out | output | 1 | Selected output clock |

## Verification
The assertions assume that the bus pins and the event pulses are synchronous to `clk`. They also assume that a strobe never changes within a clock cycle, and that the host never ends a write or read in the same cycle as an address-latch transition. The bench drives every input a short time after a rising edge and holds it for whole cycles. Its bus tasks separate the address, strobe and release phases by at least one cycle. They never overlap a write strobe with a read strobe.

// File: rtl/modem_regif_pkg.sv
package modem_regif_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRLA  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CTRLB  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_DETECT = 3'd2;
  localparam logic [ADDR_W-1:0] RA_TONE   = 3'd3;

  localparam int unsigned CTRLA_DPSK_BIT    = 0;
  localparam int unsigned CTRLB_BAUDSEL_BIT = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              sel;
  } bus_latch_t;
endpackage

// File: rtl/modem_bus_latch.sv
module modem_bus_latch
  import modem_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_in,
  output bus_latch_t        lat_q,
  output logic              wr_pulse,
  output logic              rd_end
);
  logic       ale_q, rd_q, wr_q;
  logic       ale_fall;
  bus_latch_t lat_d;

  assign ale_fall = ale_q & ~ale;
  assign wr_pulse = ~wr_q & wr_n;
  assign rd_end   = ~rd_q & rd_n;

  always_comb begin
    lat_d = lat_q;
    if (ale_fall) begin
      lat_d.addr = addr_in;
      lat_d.sel  = ~cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q <= 1'b0;
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      lat_q <= '0;
    end else begin
      ale_q <= ale;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/modem_reg_bank.sv
module modem_reg_bank
  import modem_regif_pkg::*;
#(
  parameter int unsigned DET_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_latch_t        lat,
  input  logic              wr_pulse,
  input  logic              rd_end,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [DET_W-1:0]  det_evt,
  output logic [BUS_W-1:0]  rdata,
  output logic [BUS_W-1:0]  ctrla_q,
  output logic [BUS_W-1:0]  ctrlb_q,
  output logic [BUS_W-1:0]  tone_q,
  output logic [DET_W-1:0]  det_q
);
  logic             wr_en, det_clr;
  logic             ctrla_en, ctrlb_en, tone_en;
  logic [BUS_W-1:0] ctrla_d, ctrlb_d, tone_d;
  logic [DET_W-1:0] det_d;
  logic [BUS_W-1:0] det_ext;

  assign wr_en    = wr_pulse & lat.sel;
  assign ctrla_en = wr_en & (lat.addr == RA_CTRLA);
  assign ctrlb_en = wr_en & (lat.addr == RA_CTRLB);
  assign tone_en  = wr_en & (lat.addr == RA_TONE);
  assign det_clr  = rd_end & lat.sel & (lat.addr == RA_DETECT);

  always_comb begin
    ctrla_d = ctrla_en ? wdata : ctrla_q;
    ctrlb_d = ctrlb_en ? wdata : ctrlb_q;
    tone_d  = tone_en  ? wdata : tone_q;
  end

  for (genvar i = 0; i < DET_W; i++) begin : g_flag
    assign det_d[i] = det_evt[i] | (det_q[i] & ~det_clr);
  end

  always_comb begin
    det_ext = '0;
    for (int j = 0; j < DET_W; j++) det_ext[j] = det_q[j];
  end

  always_comb begin
    unique case (lat.addr)
      RA_CTRLA:  rdata = ctrla_q;
      RA_CTRLB:  rdata = ctrlb_q;
      RA_DETECT: rdata = det_ext;
      RA_TONE:   rdata = tone_q;
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrla_q <= '0;
      ctrlb_q <= '0;
      tone_q  <= '0;
      det_q   <= '0;
    end else begin
      ctrla_q <= ctrla_d;
      ctrlb_q <= ctrlb_d;
      tone_q  <= tone_d;
      det_q   <= det_d;
    end
  end
endmodule

// File: rtl/modem_clk_sel.sv
module modem_clk_sel #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dpsk_on,
  input  logic baud_req,
  output logic clk_out
);
  localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             baud_q, baud_d;
  logic             wrap, use_baud;

  assign wrap     = (cnt_q == CNT_LAST);
  assign use_baud = dpsk_on & baud_req;

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    baud_d = wrap ? ~baud_q : baud_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      baud_q <= baud_d;
    end
  end

  assign clk_out = use_baud ? baud_q : clk;
endmodule

// File: rtl/modem_regif.sv
module modem_regif
  import modem_regif_pkg::*;
#(
  parameter int unsigned DET_W    = 4,
  parameter int unsigned DIV_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [7:0]       ad_in,
  output logic [7:0]       ad_out,
  output logic             ad_oe,
  input  logic [DET_W-1:0] det_evt,
  output logic             irq_n,
  output logic             clk_out
);
  bus_latch_t       lat_q;
  logic             wr_pulse, rd_end;
  logic [BUS_W-1:0] rdata, ctrla_q, ctrlb_q, tone_q;
  logic [DET_W-1:0] det_q;
  logic             cs_lat;

  modem_bus_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr_in(ad_in[ADDR_W-1:0]), .lat_q(lat_q),
    .wr_pulse(wr_pulse), .rd_end(rd_end)
  );

  modem_reg_bank #(.DET_W(DET_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .lat(lat_q), .wr_pulse(wr_pulse),
    .rd_end(rd_end), .wdata(ad_in), .det_evt(det_evt), .rdata(rdata),
    .ctrla_q(ctrla_q), .ctrlb_q(ctrlb_q), .tone_q(tone_q), .det_q(det_q)
  );

  modem_clk_sel #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .dpsk_on(ctrla_q[CTRLA_DPSK_BIT]),
    .baud_req(ctrlb_q[CTRLB_BAUDSEL_BIT]), .clk_out(clk_out)
  );

  assign cs_lat = lat_q.sel;
  assign ad_oe  = ~rd_n & cs_lat;
  assign ad_out = ad_oe ? rdata : '0;
  assign irq_n  = ~(|det_q);
endmodule

// File: rtl/modem_regif_chk.sv
module modem_regif_chk #(
  parameter int unsigned DET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             ad_oe,
  input logic             irq_n,
  input logic [DET_W-1:0] det_evt,
  input logic [7:0]       ctrla,
  input logic [7:0]       tone,
  input logic             cs_lat
);
  p_oe_needs_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !rd_n);

  p_tone_hold_nocs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lat |=> $stable(tone));

  p_ctrl_hold_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(wr_n) |=> $stable(ctrla));

  p_evt_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_evt) |=> !irq_n);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !$rose(rd_n)) |=> !irq_n);
endmodule

bind modem_regif modem_regif_chk #(.DET_W(DET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .irq_n(irq_n), .det_evt(det_evt), .ctrla(ctrla_q), .tone(tone_q),
  .cs_lat(cs_lat)
);

// File: tb/modem_regif_test.sv
`timescale 1ns/1ps
module modem_regif_test;
  localparam int DET_W = 4;
  localparam int DIV_HALF = 4;

  logic clk = 1'b0;
  logic rst_n, ale, cs_n, rd_n, wr_n;
  logic [7:0] ad_in;
  logic [7:0] ad_out;
  logic ad_oe, irq_n, clk_out;
  logic [DET_W-1:0] det_evt;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  modem_regif #(.DET_W(DET_W), .DIV_HALF(DIV_HALF)) uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .det_evt(det_evt), .irq_n(irq_n), .clk_out(clk_out)
  );

  // behavioural reference
  logic [7:0] m_reg [8];
  int m_addr, m_cnt;
  bit m_sel, m_aleq, m_rdq, m_wrq, m_bq;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_baud();
    return m_reg[0][0] && m_reg[1][0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 8'h00;
      m_addr = 0; m_sel = 0; m_aleq = 0; m_rdq = 1; m_wrq = 1;
      m_cnt = 0; m_bq = 0;
    end else begin
      if (!m_rdq && rd_n && m_sel && m_addr == 2) m_reg[2] = 8'h00;
      m_reg[2] = m_reg[2] | 8'(det_evt);
      if (!m_wrq && wr_n && m_sel && (m_addr == 0 || m_addr == 1 || m_addr == 3))
        m_reg[m_addr] = ad_in;
      if (m_aleq && !ale) begin
        m_addr = int'(ad_in[2:0]);
        m_sel = !cs_n;
      end
      m_aleq = ale; m_rdq = rd_n; m_wrq = wr_n;
      if (m_cnt == DIV_HALF - 1) begin m_cnt = 0; m_bq = !m_bq; end
      else m_cnt++;
    end
  end

  // compare on every clock, at the falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      bit eoe;
      logic [7:0] eout;
      eoe = !rd_n && m_sel;
      eout = eoe ? ((m_addr <= 3) ? m_reg[m_addr] : 8'h00) : 8'h00;
      check(ad_oe === eoe, "R4 ad_oe", int'(ad_oe), int'(eoe));
      check(ad_out === eout, "R5 ad_out", int'(ad_out), int'(eout));
      check(irq_n === (m_reg[2] == 0), "R7 irq_n", int'(irq_n), int'(m_reg[2] == 0));
      check(clk_out === (m_baud() ? m_bq : 1'b0), "R9 clk_out", int'(clk_out),
            int'(m_baud() ? m_bq : 1'b0));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic addr_phase(input logic [2:0] a, input bit sel);
    ale = 1; ad_in = {5'b0, a}; cs_n = !sel; step();
    ale = 0; step();
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit sel);
    addr_phase(a, sel);
    ad_in = d; wr_n = 0; step();
    wr_n = 1; step();
  endtask

  task automatic bus_read(input logic [2:0] a, input bit sel, output logic [7:0] d);
    addr_phase(a, sel);
    rd_n = 0; step();
    @(negedge clk); d = ad_out;
    step();
    rd_n = 1; step();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; ale = 0; cs_n = 1; rd_n = 1; wr_n = 1; ad_in = 0; det_evt = 0;
    step(3);
    rst_n = 1; step(2);

    // R8: reset state
    bus_read(3'd0, 1, d); check(d == 8'h00, "R8 ctrlA after reset", d, 0);
    bus_read(3'd3, 1, d); check(d == 8'h00, "R8 tone after reset", d, 0);
    check(irq_n === 1'b1, "R8 irq_n after reset", irq_n, 1);

    // R1 R3: writes land at latched address
    bus_write(3'd0, 8'hA4, 1);
    bus_write(3'd3, 8'h3C, 1);
    bus_write(3'd1, 8'h5A, 1);
    bus_read(3'd0, 1, d); check(d == 8'hA4, "R1 R3 ctrlA readback", d, 8'hA4);
    bus_read(3'd3, 1, d); check(d == 8'h3C, "R1 R3 tone readback", d, 8'h3C);
    bus_read(3'd1, 1, d); check(d == 8'h5A, "R1 R3 ctrlB readback", d, 8'h5A);

    // R2 R4: latched chip select inactive, live cs_n low during write
    addr_phase(3'd3, 0);
    cs_n = 0; ad_in = 8'hFF; wr_n = 0; step(); wr_n = 1; step();
    rd_n = 0; step();
    check(ad_oe === 1'b0, "R4 no drive without latched cs", ad_oe, 0);
    rd_n = 1; step();
    bus_read(3'd3, 1, d); check(d == 8'h3C, "R2 tone unchanged", d, 8'h3C);

    // R2: cs_n raised after latch still allows write
    addr_phase(3'd3, 1);
    cs_n = 1; ad_in = 8'h77; wr_n = 0; step(); wr_n = 1; step();
    bus_read(3'd3, 1, d); check(d == 8'h77, "R2 write with latched cs", d, 8'h77);

    // R5: read-only detect and unused addresses
    bus_write(3'd2, 8'h0F, 1);
    bus_read(3'd2, 1, d); check(d == 8'h00, "R5 detect write ignored", d, 0);
    bus_write(3'd5, 8'h99, 1);
    bus_read(3'd5, 1, d); check(d == 8'h00, "R5 unused reads zero", d, 0);

    // R6 R7: event sets flag, read clears it
    det_evt = 4'b0100; step(); det_evt = 0; step();
    check(irq_n === 1'b0, "R7 irq low on flag", irq_n, 0);
    bus_read(3'd2, 1, d); check(d == 8'h04, "R6 detect flag value", d, 8'h04);
    check(irq_n === 1'b1, "R6 irq released by read", irq_n, 1);

    // R6: event coincident with clearing read stays set
    det_evt = 4'b0001; step(); det_evt = 0;
    addr_phase(3'd2, 1);
    rd_n = 0; step(2);
    rd_n = 1; det_evt = 4'b1000; step(); det_evt = 0; step();
    check(irq_n === 1'b0, "R6 coincident event kept", irq_n, 0);
    bus_read(3'd2, 1, d); check(d == 8'h08, "R6 only coincident flag left", d, 8'h08);

    // R9: clock selection
    bus_write(3'd0, 8'h00, 1);
    bus_write(3'd1, 8'h01, 1);
    #5; check(clk_out === 1'b1, "R9 crystal high phase", clk_out, 1);
    step();
    bus_write(3'd0, 8'h01, 1);
    step(20);
    bus_write(3'd0, 8'h00, 1);
    #5; check(clk_out === 1'b1, "R9 back to crystal", clk_out, 1);
    step(3);

    // R8: reset mid-operation
    bus_write(3'd3, 8'h12, 1);
    det_evt = 4'b0010; step(); det_evt = 0;
    rst_n = 0; step(2); rst_n = 1; step(2);
    check(irq_n === 1'b1, "R8 flags cleared", irq_n, 1);
    rd_n = 0; step();
    check(ad_oe === 1'b0, "R8 latched cs cleared", ad_oe, 0);
    rd_n = 1; step();
    bus_read(3'd3, 1, d); check(d == 8'h00, "R8 tone cleared", d, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule